// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting channel of the kind found in programmable interval timers. A load strobe delivers a new initial count. A clock-enable input paces the counting. A gate input either pauses counting or retriggers it, depending on the selected mode. The channel produces an output level whose waveform depends on the mode: a terminal-count flag, a one-shot, a rate pulse, a square wave, or a single strobe pulse. It also reports the current count value.

Internally every mode is derived from one measure: the number of enabled ticks since the last load or retrigger. That measure is held as three registers: a saturating total, its remainder modulo the loaded count, and its low 16 bits. The output level and the reported count are decoded combinationally from these registers and the mode, so both ports show the new state in the cycle after the clock edge that caused it.

Top module: `pit_chan`

## Requirements
- R1: After reset the loaded count is 65536 and the elapsed-tick measure is zero. With mode 0 selected, `curCount` reads 0 and `outLevel` is low.
- R2: Mode 0. `outLevel` is high once the elapsed ticks are greater than or equal to the loaded count, and it stays high until the next load.
- R3: Mode 1. `outLevel` is high exactly while the elapsed ticks are below the loaded count, so it goes high in the cycle after a load.
- R4: Mode 2. `outLevel` is high while the elapsed ticks are a nonzero multiple of the loaded count, and low otherwise.
- R5: Mode 3. `outLevel` is high while (elapsed mod count) is below (count+1)/2, and low for the rest of each period.
- R6: Modes 4 and 5. `outLevel` is high only while the elapsed ticks equal the loaded count, which is a single tick interval.
- R7: Modes 0, 1, 4 and 5. `curCount` equals (count − elapsed) mod 65536.
- R8: Mode 2 reports count − (elapsed mod count). Mode 3 reports count − ((2·elapsed) mod count). Both results are taken mod 65536.
- R9: Modes 1, 2, 3 and 5. A rising gate edge restarts the elapsed measure at zero and keeps the loaded count. The edge is the gate sampled high when the previous cycle's sample was low; the sample before the first cycle after reset counts as low. A restart overrides a tick in the same cycle.
- R10: Modes 0 and 4. While the gate is low, ticks are ignored and `curCount` holds its value.
- R11: A loaded value of 0 acts as a count of 65536.
- R12: A load sets the elapsed measure to zero. It overrides any tick or gate restart in the same cycle, so a load of V in mode 0 or mode 1 reads back V in the next cycle.
- R13: Mode codes 6 and 7 behave exactly as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable; one elapsed tick per enabled cycle |
| gate | input | 1 | Gate level: enables counting in modes 0 and 4; its rising edge retriggers in modes 1, 2, 3 and 5 |
| loadStrobe | input | 1 | Load a new initial count this cycle |
| loadValue | input | WIDTH (16) | Initial count; 0 means 65536 |
| modeSel | input | 3 | Operating mode 0 to 7 (6 and 7 alias to 2 and 3) |
| curCount | output | WIDTH (16) | Current count value as reported for the selected mode |
| outLevel | output | 1 | Mode-dependent output level |

## Verification
The three elapsed-tick registers must stay consistent, so a wrong internal value shows at the ports within one period of the loaded count. A remainder that is off by one moves the mode 2 pulse and the mode 3 edge by one tick, and `curCount` shows the error in the first cycle after the faulty tick. A saturating total that misses the terminal count leaves `outLevel` wrong at tick N in modes 0, 1, 4 and 5. A missed or spurious retrigger makes `curCount` jump back to the loaded value, or fail to jump back, in the cycle after the gate edge. The bench compares both ports on every cycle against a model that computes the required value directly from an unbounded elapsed count.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

  typedef enum logic [2:0] {
    MODE_TC_INT    = 3'd0,
    MODE_ONESHOT   = 3'd1,
    MODE_RATE      = 3'd2,
    MODE_SQUARE    = 3'd3,
    MODE_SW_STROBE = 3'd4,
    MODE_HW_STROBE = 3'd5
  } chanMode_e;

  typedef struct packed {
    logic load;
    logic restart;
    logic advance;
  } chanStrobe_t;

endpackage

// File: rtl/pit_chan_ctrl.sv
module pit_chan_ctrl
  import pit_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        gate,
  input  logic        loadStrobe,
  input  logic [2:0]  modeSel,
  output chanStrobe_t strobe,
  output chanMode_e   effMode
);

  logic gatePrev;
  logic gateRise;
  logic levelGated;
  logic edgeTrig;

  always_ff @(posedge clk) begin
    if (!rstN) gatePrev <= 1'b0;
    else       gatePrev <= gate;
  end

  always_comb begin
    if (modeSel[2:1] == 2'b11) effMode = chanMode_e'({1'b0, modeSel[1:0]});
    else                       effMode = chanMode_e'(modeSel);
    levelGated = (effMode == MODE_TC_INT) || (effMode == MODE_SW_STROBE);
    edgeTrig   = !levelGated;
    gateRise   = gate && !gatePrev;
    strobe.load    = loadStrobe;
    strobe.restart = gateRise && edgeTrig;
    strobe.advance = tick && (gate || !levelGated);
  end

endmodule

// File: rtl/pit_chan_dp.sv
module pit_chan_dp
  import pit_chan_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobe_t      strobe,
  input  chanMode_e        effMode,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] curCount,
  output logic             outLevel
);

  localparam int EXT = WIDTH + 1;
  localparam logic [EXT-1:0] FULL = EXT'(1) << WIDTH;
  localparam logic [EXT-1:0] SAT  = '1;

  logic [EXT-1:0]   period;
  logic [EXT-1:0]   elapsedSat;
  logic [EXT-1:0]   phase;
  logic [WIDTH-1:0] elapsedLow;

  logic [EXT-1:0] phaseNext;
  logic [EXT-1:0] twoPhase;
  logic [EXT-1:0] dblMod;
  logic [EXT-1:0] halfPeriod;
  logic [EXT-1:0] rateCnt;
  logic [EXT-1:0] sqCnt;
  logic [WIDTH-1:0] linCnt;
  logic reached;
  logic atTerm;

  assign phaseNext = phase + EXT'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      period     <= FULL;
      elapsedSat <= '0;
      phase      <= '0;
      elapsedLow <= '0;
    end else if (strobe.load) begin
      period     <= (loadValue == '0) ? FULL : {1'b0, loadValue};
      elapsedSat <= '0;
      phase      <= '0;
      elapsedLow <= '0;
    end else if (strobe.restart) begin
      elapsedSat <= '0;
      phase      <= '0;
      elapsedLow <= '0;
    end else if (strobe.advance) begin
      elapsedSat <= (elapsedSat == SAT) ? SAT : elapsedSat + EXT'(1);
      phase      <= (phaseNext == period) ? '0 : phaseNext;
      elapsedLow <= elapsedLow + WIDTH'(1);
    end
  end

  always_comb begin
    twoPhase   = {phase[EXT-2:0], 1'b0};
    dblMod     = (twoPhase >= period) ? twoPhase - period : twoPhase;
    halfPeriod = (period + EXT'(1)) >> 1;
    reached    = elapsedSat >= period;
    atTerm     = elapsedSat == period;
    linCnt     = period[WIDTH-1:0] - elapsedLow;
    rateCnt    = period - phase;
    sqCnt      = period - dblMod;
    case (effMode)
      MODE_TC_INT: begin
        outLevel = reached;
        curCount = linCnt;
      end
      MODE_ONESHOT: begin
        outLevel = !reached;
        curCount = linCnt;
      end
      MODE_RATE: begin
        outLevel = (phase == '0) && (elapsedSat != '0);
        curCount = rateCnt[WIDTH-1:0];
      end
      MODE_SQUARE: begin
        outLevel = phase < halfPeriod;
        curCount = sqCnt[WIDTH-1:0];
      end
      default: begin
        outLevel = atTerm;
        curCount = linCnt;
      end
    endcase
  end

endmodule

// File: rtl/pit_chan.sv
module pit_chan
  import pit_chan_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             gate,
  input  logic             loadStrobe,
  input  logic [WIDTH-1:0] loadValue,
  input  logic [2:0]       modeSel,
  output logic [WIDTH-1:0] curCount,
  output logic             outLevel
);

  chanStrobe_t strobe;
  chanMode_e   effMode;

  pit_chan_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .gate       (gate),
    .loadStrobe (loadStrobe),
    .modeSel    (modeSel),
    .strobe     (strobe),
    .effMode    (effMode)
  );

  pit_chan_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .effMode   (effMode),
    .loadValue (loadValue),
    .curCount  (curCount),
    .outLevel  (outLevel)
  );

endmodule

// File: rtl/pit_chan_chk.sv
module pit_chan_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             gate,
  input logic             loadStrobe,
  input logic [WIDTH-1:0] loadValue,
  input logic [2:0]       modeSel,
  input logic [WIDTH-1:0] curCount,
  input logic             outLevel
);

  // R2: terminal-count flag is sticky until the next load
  assert_tc_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd0 && outLevel && !loadStrobe) |=> (modeSel != 3'd0 || outLevel));

  // R3: one-shot output rises right after a load
  assert_oneshot_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && modeSel == 3'd1) |=> (modeSel != 3'd1 || outLevel));

  // R6: strobe lasts no more than one tick
  assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd4 && outLevel && tick && gate && !loadStrobe) |=> (modeSel != 3'd4 || !outLevel));

  // R10: gate low freezes counting in mode 0
  assert_gate_freeze_R10: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd0 && !gate && !loadStrobe) |=> (modeSel != 3'd0 || $stable(curCount)));

  // R12: a load reads back its value on the next cycle
  assert_load_readback_R12: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && modeSel == 3'd1) |=> (modeSel != 3'd1 || curCount == $past(loadValue)));

endmodule

bind pit_chan pit_chan_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tick       (tick),
  .gate       (gate),
  .loadStrobe (loadStrobe),
  .loadValue  (loadValue),
  .modeSel    (modeSel),
  .curCount   (curCount),
  .outLevel   (outLevel)
);

// File: tb/sim_pit_chan.sv
`timescale 1ns/1ps
module sim_pit_chan;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        gate = 1'b1;
  logic        loadStrobe = 1'b0;
  logic [15:0] loadValue = '0;
  logic [2:0]  modeSel = 3'd0;
  logic [15:0] curCount;
  logic        outLevel;

  int checks = 0;
  int errors = 0;

  longint mN = 65536;
  longint mD = 0;
  logic   mGp = 1'b0;

  always #5 clk = ~clk;

  pit_chan u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .gate(gate),
    .loadStrobe(loadStrobe), .loadValue(loadValue), .modeSel(modeSel),
    .curCount(curCount), .outLevel(outLevel)
  );

  typedef struct packed {
    logic [2:0]  m;
    logic [15:0] ld;
    logic [3:0]  div;
    logic [9:0]  len;
    logic [9:0]  gateLowAt;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{3'd0, 16'd5, 4'd1, 10'd12, 10'd0},
    '{3'd0, 16'd4, 4'd1, 10'd14, 10'd3},
    '{3'd1, 16'd3, 4'd1, 10'd10, 10'd6},
    '{3'd2, 16'd3, 4'd1, 10'd14, 10'd0},
    '{3'd2, 16'd4, 4'd2, 10'd20, 10'd9},
    '{3'd3, 16'd4, 4'd1, 10'd14, 10'd0},
    '{3'd3, 16'd5, 4'd1, 10'd16, 10'd0},
    '{3'd3, 16'd7, 4'd1, 10'd20, 10'd11},
    '{3'd4, 16'd3, 4'd1, 10'd10, 10'd5},
    '{3'd5, 16'd3, 4'd1, 10'd10, 10'd6},
    '{3'd6, 16'd3, 4'd1, 10'd10, 10'd0},
    '{3'd7, 16'd5, 4'd1, 10'd12, 10'd0},
    '{3'd2, 16'd1, 4'd1, 10'd6,  10'd0},
    '{3'd3, 16'd1, 4'd1, 10'd6,  10'd0}
  };

  function automatic int aliasMode(input logic [2:0] m);
    return (m >= 3'd6) ? int'(m) - 4 : int'(m);
  endfunction

  function automatic logic expOut(input logic [2:0] m, input longint n, input longint d);
    case (aliasMode(m))
      0: return d >= n;
      1: return d < n;
      2: return (d % n == 0) && (d != 0);
      3: return (d % n) < ((n + 1) / 2);
      default: return d == n;
    endcase
  endfunction

  function automatic logic [15:0] expCnt(input logic [2:0] m, input longint n, input longint d);
    longint r;
    case (aliasMode(m))
      2: r = n - (d % n);
      3: r = n - ((2 * d) % n);
      default: r = n - d;
    endcase
    return 16'(r & 65535);
  endfunction

  function automatic string outTag(input logic [2:0] m);
    if (m >= 3'd6) return "R13";
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic string cntTag(input logic [2:0] m);
    if (m >= 3'd6) return "R13";
    if (m == 3'd2 || m == 3'd3) return "R8";
    return "R7";
  endfunction

  task automatic checkVal(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one cycle at a negedge, update model at the posedge, compare at the next negedge
  task automatic step(input logic t, input logic g, input logic ld, input logic [15:0] lv);
    int am;
    tick = t; gate = g; loadStrobe = ld; loadValue = lv;
    @(posedge clk);
    am = aliasMode(modeSel);
    if (ld) begin
      mN = (lv == 16'd0) ? 65536 : longint'(lv);
      mD = 0;
    end else if (g && !mGp && (am == 1 || am == 2 || am == 3 || am == 5)) begin
      mD = 0;
    end else if (t && (g || !(am == 0 || am == 4))) begin
      mD = mD + 1;
    end
    mGp = g;
    @(negedge clk);
    checkVal(outTag(modeSel), longint'(outLevel), longint'(expOut(modeSel, mN, mD)));
    checkVal(cntTag(modeSel), longint'(curCount), longint'(expCnt(modeSel, mN, mD)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state in mode 0
    checkVal("R1", longint'(curCount), 0);
    checkVal("R1", longint'(outLevel), 0);

    foreach (VEC[k]) begin
      modeSel = VEC[k].m;
      step(1'b1, 1'b1, 1'b1, VEC[k].ld);
      for (int i = 0; i < int'(VEC[k].len); i++) begin
        step((i % int'(VEC[k].div)) == 0,
             !(VEC[k].gateLowAt != 0 && i == int'(VEC[k].gateLowAt)),
             1'b0, 16'd0);
      end
    end

    // R11: zero load counts as 65536
    modeSel = 3'd0;
    step(1'b0, 1'b1, 1'b1, 16'd0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 16'd0);
    checkVal("R11", longint'(curCount), 65533);
    checkVal("R11", longint'(outLevel), 0);

    // R12: load wins over a tick in the same cycle
    step(1'b1, 1'b1, 1'b1, 16'd9);
    checkVal("R12", longint'(curCount), 9);

    // R10: mode 4 ignores ticks while gate is low
    modeSel = 3'd4;
    step(1'b0, 1'b1, 1'b1, 16'd5);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 16'd0);
    checkVal("R10", longint'(curCount), 5);

    // R9: mode 5 retrigger on gate rise, restart beats tick
    modeSel = 3'd5;
    step(1'b0, 1'b1, 1'b1, 16'd2);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 16'd0);
    step(1'b0, 1'b0, 1'b0, 16'd0);
    step(1'b1, 1'b1, 1'b0, 16'd0);
    checkVal("R9", longint'(curCount), 2);
    checkVal("R9", longint'(outLevel), 0);

    // R13: mode 7 square wave with count 2
    modeSel = 3'd7;
    step(1'b0, 1'b1, 1'b1, 16'd2);
    checkVal("R13", longint'(outLevel), 1);
    step(1'b1, 1'b1, 1'b0, 16'd0);
    checkVal("R13", longint'(outLevel), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule